// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block is the configuration access unit of a host bridge. A host reaches it through a simple memory-mapped port split into two 4 KiB windows. The first window holds a 32-bit index register. Any read or write that lands in the second window becomes one configuration cycle on a request channel. The block returns the result of that cycle to the host once the bus side answers on the response channel.

The index register can be written in three layouts. Flag bits 31 and 0 of the index choose the layout. The block rewrites the stored value into the standard bus/device/function/register address form, and it takes the lowest address bits from the data-window access. In the one-hot device-select layout, the device number is the position of the lowest set select bit. Byte enables come from the access size and the low address bits. Data is little-endian, and read data is shifted down to the accessed lane.

Top module: `pci_cfg_xlate`

## Requirements
- R1: `host_addr[12]` low selects the index window and high selects the data window, and `host_addr[11:0]` is the offset inside the window. In the index window, the 4-byte word at offset 0 is the index register. It is readable and writable and resets to zero. Any other index-window offset reads as zero, and writes to it are ignored.
- R2: When index bit 31 is set, the request address is the index value ORed with the data-window offset bits [1:0]. All other offset bits are ignored.
- R3: When index bit 31 is clear and bit 0 is set, the request address is the index with bits [2:0] cleared, ORed with data-window offset bits [2:0].
- R4: When index bits 31 and 0 are both clear, the device number is the bit position, counted from bit 0, of the lowest set bit in index bits [31:11]. The request address is formed as follows:
  - the device number goes in bits [15:11];
  - index bits [10:8] give the function number in bits [10:8];
  - index bits [7:3] go in bits [7:3];
  - data-window offset bits [2:0] go in bits [2:0].
- R5: In the layout of R4, if index bits [31:11] are all zero, no request is issued. The access completes one cycle after acceptance. A read returns 0xFFFFFFFF, and a write is dropped.
- R6: `host_size` encodes the access size: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. The byte-enable mask of that width is shifted left by offset bits [1:0], and lanes past lane 3 are dropped. Write data is taken right-aligned from `host_wdata` and shifted up by 8 times offset bits [1:0]. A read request carries zero write data. Index-window writes use the same enables.
- R7: Read data is shifted down by 8 times offset bits [1:0] and then masked to the access width. This applies both to the index register and to `rsp_rdata`.
- R8: Each data-window access that passes translation issues exactly one request. `req_valid` and all request fields stay stable until `rsp_valid` is seen. `host_done` pulses in the following cycle, and `req_valid` drops in that same cycle. `host_valid` is ignored while a request is outstanding, and the idle state after reset has `req_valid` and `host_done` low.
- R9: An index-window access completes with `host_done` one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access strobe, accepted when idle |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | 13 | Bit 12 selects the window; bits [11:0] give the offset |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Right-aligned write data |
| host_done | output | 1 | Completion pulse |
| host_rdata | output | 32 | Lane-aligned read data, valid with host_done |
| req_valid | output | 1 | Configuration request pending |
| req_write | output | 1 | Request direction |
| req_addr | output | 32 | Translated configuration address |
| req_be | output | 4 | Byte enables |
| req_wdata | output | 32 | Lane-positioned write data |
| rsp_valid | input | 1 | Response handshake |
| rsp_rdata | input | 32 | Response read data |

## Verification
The assertions check the request handshake on every cycle: the request fields hold steady while waiting, completion follows the response by one cycle, completion never overlaps an outstanding request, and byte enables are never empty. They also tie each new request to the index layout in force: the flag-bit-31 and type-1 address prefixes, and the rule that no request is issued for an empty device select. The bench scenarios are needed for the following:
- the lowest-bit device decode;
- the lane shifting and masking of data;
- the all-ones return on an invalid access;
- partial writes to the index register;
- an access that arrives while busy being ignored.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    XM_RAW   = 2'd0,
    XM_TYPE1 = 2'd1,
    XM_TYPE0 = 2'd2
  } xlate_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/cfgx_lsb_find.sv
module cfgx_lsb_find #(
  parameter int unsigned W  = 21,
  parameter int unsigned PW = 5
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        pos   = PW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
  import cfgx_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned DEV_LSB  = 11,
  parameter int unsigned FUNC_LSB = 8,
  parameter int unsigned RAW_BIT  = 31
) (
  input  logic [WORD_W-1:0] idx,
  input  logic [2:0]        lo,
  output logic [WORD_W-1:0] addr,
  output logic              ok
);
  localparam int unsigned SEL_W = WORD_W - DEV_LSB;
  localparam int unsigned POS_W = $clog2(WORD_W);

  logic [POS_W-1:0]  pos;
  logic              found;
  logic [POS_W-1:0]  dev;
  logic [WORD_W-1:0] t0_addr;
  xlate_mode_e       mode;

  cfgx_lsb_find #(.W(SEL_W), .PW(POS_W)) u_find (
    .vec  (idx[WORD_W-1:DEV_LSB]),
    .pos  (pos),
    .found(found)
  );

  always_comb begin
    if (idx[RAW_BIT])  mode = XM_RAW;
    else if (idx[0])   mode = XM_TYPE1;
    else               mode = XM_TYPE0;
  end

  assign dev = pos + POS_W'(DEV_LSB);

  always_comb begin
    t0_addr                    = '0;
    t0_addr[2:0]               = lo;
    t0_addr[FUNC_LSB-1:3]      = idx[FUNC_LSB-1:3];
    t0_addr[FUNC_LSB+:3]       = idx[FUNC_LSB+:3];
    t0_addr[DEV_LSB+:POS_W]    = dev;
  end

  always_comb begin
    case (mode)
      XM_RAW: begin
        addr = idx | WORD_W'(lo[1:0]);
        ok   = 1'b1;
      end
      XM_TYPE1: begin
        addr = {idx[WORD_W-1:3], lo};
        ok   = 1'b1;
      end
      XM_TYPE0: begin
        addr = t0_addr;
        ok   = found;
      end
      default: begin
        addr = '0;
        ok   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cfgx_lane_unit.sv
module cfgx_lane_unit #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANE_W = $clog2(WORD_W / 8)
) (
  input  logic [1:0]            size,
  input  logic [LANE_W-1:0]     lane,
  input  logic [WORD_W-1:0]     wdata_in,
  input  logic [WORD_W-1:0]     rdata_in,
  output logic [WORD_W/8-1:0]   be,
  output logic [WORD_W-1:0]     wdata_out,
  output logic [WORD_W-1:0]     rdata_out
);
  localparam int unsigned LANES = WORD_W / 8;

  logic [LANES-1:0]  span;
  logic [WORD_W-1:0] keep;

  always_comb begin
    case (size)
      2'd0:    span = LANES'(1);
      2'd1:    span = LANES'(3);
      default: span = '1;
    endcase
  end

  for (genvar b = 0; b < LANES; b++) begin : g_keep
    assign keep[b*8+:8] = {8{span[b]}};
  end

  assign be        = span << lane;
  assign wdata_out = wdata_in << {lane, 3'b000};
  assign rdata_out = (rdata_in >> {lane, 3'b000}) & keep;
endmodule

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg #(
  parameter int unsigned WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [WORD_W/8-1:0]   wr_be,
  input  logic [WORD_W-1:0]     wr_data,
  output logic [WORD_W-1:0]     q
);
  localparam int unsigned LANES = WORD_W / 8;

  for (genvar b = 0; b < LANES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        q[b*8+:8] <= '0;
      else if (wr_en && wr_be[b])
        q[b*8+:8] <= wr_data[b*8+:8];
    end
  end
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
  import cfgx_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WIN_AW = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_valid,
  input  logic                host_write,
  input  logic [WIN_AW:0]     host_addr,
  input  logic [1:0]          host_size,
  input  logic [WORD_W-1:0]   host_wdata,
  output logic                host_done,
  output logic [WORD_W-1:0]   host_rdata,
  output logic                req_valid,
  output logic                req_write,
  output logic [WORD_W-1:0]   req_addr,
  output logic [WORD_W/8-1:0] req_be,
  output logic [WORD_W-1:0]   req_wdata,
  input  logic                rsp_valid,
  input  logic [WORD_W-1:0]   rsp_rdata
);
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  ctl_state_e        state;
  logic [1:0]        held_size;
  logic [LANE_W-1:0] held_lane;
  logic              held_write;

  logic              accept;
  logic              win_data;
  logic              idx_hit;
  logic              idx_wr;
  logic [WORD_W-1:0] idx_q;
  logic [WORD_W-1:0] idx_rd;
  logic [WORD_W-1:0] xl_addr;
  logic              xl_ok;

  logic [1:0]        ln_size;
  logic [LANE_W-1:0] ln_lane;
  logic [WORD_W-1:0] ln_rin;
  logic [LANES-1:0]  ln_be;
  logic [WORD_W-1:0] ln_wdata;
  logic [WORD_W-1:0] ln_rdata;

  assign accept   = host_valid && (state == ST_IDLE);
  assign win_data = host_addr[WIN_AW];
  assign idx_hit  = (host_addr[WIN_AW-1:LANE_W] == '0);
  assign idx_wr   = accept && !win_data && host_write && idx_hit;
  assign idx_rd   = idx_hit ? idx_q : '0;

  cfgx_index_reg #(.WORD_W(WORD_W)) u_index (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (idx_wr),
    .wr_be  (ln_be),
    .wr_data(ln_wdata),
    .q      (idx_q)
  );

  cfgx_xlate #(.WORD_W(WORD_W)) u_xlate (
    .idx (idx_q),
    .lo  (host_addr[2:0]),
    .addr(xl_addr),
    .ok  (xl_ok)
  );

  // One lane unit: host-side fields while idle, latched fields while waiting
  always_comb begin
    if (state == ST_WAIT) begin
      ln_size = held_size;
      ln_lane = held_lane;
      ln_rin  = rsp_rdata;
    end else begin
      ln_size = host_size;
      ln_lane = host_addr[LANE_W-1:0];
      ln_rin  = idx_rd;
    end
  end

  cfgx_lane_unit #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_lane (
    .size     (ln_size),
    .lane     (ln_lane),
    .wdata_in (host_wdata),
    .rdata_in (ln_rin),
    .be       (ln_be),
    .wdata_out(ln_wdata),
    .rdata_out(ln_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      host_done  <= 1'b0;
      host_rdata <= '0;
      req_valid  <= 1'b0;
      req_write  <= 1'b0;
      req_addr   <= '0;
      req_be     <= '0;
      req_wdata  <= '0;
      held_size  <= '0;
      held_lane  <= '0;
      held_write <= 1'b0;
    end else begin
      host_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!win_data) begin
              host_done  <= 1'b1;
              host_rdata <= host_write ? '0 : ln_rdata;
            end else if (!xl_ok) begin
              host_done  <= 1'b1;
              host_rdata <= host_write ? '0 : '1;
            end else begin
              req_valid  <= 1'b1;
              req_write  <= host_write;
              req_addr   <= xl_addr;
              req_be     <= ln_be;
              req_wdata  <= host_write ? ln_wdata : '0;
              held_size  <= host_size;
              held_lane  <= host_addr[LANE_W-1:0];
              held_write <= host_write;
              state      <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            req_valid  <= 1'b0;
            host_done  <= 1'b1;
            host_rdata <= held_write ? '0 : ln_rdata;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_cfg_xlate_chk.sv
module pci_cfg_xlate_chk #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DEV_LSB = 11
) (
  input logic                clk,
  input logic                rst,
  input logic                host_done,
  input logic                req_valid,
  input logic                req_write,
  input logic [WORD_W-1:0]   req_addr,
  input logic [WORD_W/8-1:0] req_be,
  input logic [WORD_W-1:0]   req_wdata,
  input logic                rsp_valid,
  input logic [WORD_W-1:0]   idx_q
);
  // R8
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !rsp_valid |=> req_valid && $stable(req_addr) && $stable(req_be)
                                && $stable(req_wdata) && $stable(req_write));

  // R8
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && rsp_valid |=> host_done && !req_valid);

  // R8
  no_done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !host_done);

  // R6
  be_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_be != '0);

  // R2
  raw_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) && idx_q[WORD_W-1] |-> req_addr[WORD_W-1:2] == idx_q[WORD_W-1:2]);

  // R3
  type1_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) && !idx_q[WORD_W-1] && idx_q[0]
      |-> req_addr[WORD_W-1:3] == idx_q[WORD_W-1:3]);

  // R5
  no_empty_select_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) && !idx_q[WORD_W-1] && !idx_q[0] |-> idx_q[WORD_W-1:DEV_LSB] != '0);

  // R1
  index_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> idx_q == '0);
endmodule

bind pci_cfg_xlate pci_cfg_xlate_chk #(.WORD_W(WORD_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .host_done(host_done),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_be   (req_be),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .idx_q    (idx_q)
);

// File: tb/test_pci_cfg_xlate.sv
module test_pci_cfg_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_valid, host_write;
  logic [12:0] host_addr;
  logic [1:0]  host_size;
  logic [31:0] host_wdata;
  logic        host_done;
  logic [31:0] host_rdata;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad   = 0;
  int resp_delay = 1;

  // expected requests
  logic [31:0] rq_addr[$];
  logic [3:0]  rq_be[$];
  logic [31:0] rq_wdata[$];
  logic        rq_write[$];
  logic [31:0] rq_rsp[$];
  string       rq_tag[$];
  // expected completions
  logic [31:0] dn_rdata[$];
  logic        dn_chk[$];
  string       dn_tag[$];

  always #2 clk = ~clk;

  pci_cfg_xlate i_pci_cfg_xlate (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .host_size(host_size), .host_wdata(host_wdata),
    .host_done(host_done), .host_rdata(host_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push_req(input string tag, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] wd, input logic wr, input logic [31:0] rsp);
    rq_addr.push_back(a); rq_be.push_back(be); rq_wdata.push_back(wd);
    rq_write.push_back(wr); rq_rsp.push_back(rsp); rq_tag.push_back(tag);
  endtask

  // Driver: pushes the expected completion, issues one access, checks latency
  task automatic access(input string tag, input logic win, input logic [11:0] off,
                        input logic [1:0] sz, input logic wr, input logic [31:0] wd,
                        input logic rchk, input logic [31:0] rexp, input int exp_lat,
                        input bit stray);
    int n;
    dn_rdata.push_back(rexp); dn_chk.push_back(rchk); dn_tag.push_back(tag);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_addr = {win, off};
    host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_valid = 1'b0;
    if (stray) begin
      host_valid = 1'b1; host_write = 1'b1; host_addr = 13'h0;
      host_size = 2'd2; host_wdata = 32'hFFFF_FFFF;
    end
    n = 1;
    while (!host_done) begin
      @(negedge clk);
      host_valid = 1'b0;
      n++;
    end
    if (exp_lat > 0) check({tag, " latency"}, 32'(n), 32'(exp_lat));
  endtask

  // Responder: compares each request with the scoreboard and answers it
  initial begin
    rsp_valid = 1'b0;
    rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst && req_valid) begin
        logic [31:0] rsp;
        rsp = 32'h0;
        if (rq_addr.size() == 0) begin
          total++; bad++;
          $display("FAIL R5 unexpected request act=%h exp=none", req_addr);
        end else begin
          string t;
          t = rq_tag.pop_front();
          check({t, " addr"},  req_addr, rq_addr.pop_front());
          check({t, " be"},    {28'h0, req_be}, {28'h0, rq_be.pop_front()});
          check({t, " wdata"}, req_wdata, rq_wdata.pop_front());
          check({t, " dir"},   {31'h0, req_write}, {31'h0, rq_write.pop_front()});
          rsp = rq_rsp.pop_front();
        end
        repeat (resp_delay - 1) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_rdata = rsp;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  // Monitor: pops expected completions as the design produces them
  always @(negedge clk) begin
    if (!rst && host_done) begin
      if (dn_tag.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 unexpected completion act=%h exp=none", host_rdata);
      end else begin
        string t;
        logic  c;
        logic [31:0] e;
        t = dn_tag.pop_front();
        c = dn_chk.pop_front();
        e = dn_rdata.pop_front();
        if (c) check({t, " rdata"}, host_rdata, e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; host_valid = 1'b0; host_write = 1'b0; host_addr = '0;
    host_size = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset req_valid", {31'h0, req_valid}, 32'h0);
    check("R8 reset host_done", {31'h0, host_done}, 32'h0);

    // R1 index register reset, write, readback; R9 latency
    access("R1 idx reset read", 1'b0, 12'h000, 2'd2, 1'b0, 0, 1'b1, 32'h0, 1, 0);
    access("R9 idx write", 1'b0, 12'h000, 2'd2, 1'b1, 32'h8000_1234, 1'b0, 0, 1, 0);
    access("R1 idx readback", 1'b0, 12'h000, 2'd2, 1'b0, 0, 1'b1, 32'h8000_1234, 1, 0);
    access("R6 idx byte write", 1'b0, 12'h002, 2'd0, 1'b1, 32'h0000_00AB, 1'b0, 0, 1, 0);
    access("R1 idx after byte", 1'b0, 12'h000, 2'd2, 1'b0, 0, 1'b1, 32'h80AB_1234, 1, 0);
    access("R7 idx half read", 1'b0, 12'h002, 2'd1, 1'b0, 0, 1'b1, 32'h0000_80AB, 1, 0);
    access("R1 other offset read", 1'b0, 12'h010, 2'd2, 1'b0, 0, 1'b1, 32'h0, 1, 0);
    access("R1 other offset write", 1'b0, 12'h010, 2'd2, 1'b1, 32'h0, 1'b0, 0, 1, 0);
    access("R1 idx unchanged", 1'b0, 12'h000, 2'd2, 1'b0, 0, 1'b1, 32'h80AB_1234, 1, 0);
    access("R1 idx rewrite", 1'b0, 12'h000, 2'd2, 1'b1, 32'h8000_1234, 1'b0, 0, 1, 0);

    // R2 bit-31 layout
    push_req("R2 raw word", 32'h8000_1234, 4'hF, 32'h0, 1'b0, 32'hDEAD_BEEF);
    access("R2 raw word", 1'b1, 12'h000, 2'd2, 1'b0, 0, 1'b1, 32'hDEAD_BEEF, 2, 0);
    push_req("R2 raw byte", 32'h8000_1237, 4'h8, 32'h0, 1'b0, 32'h1122_3344);
    access("R7 raw byte", 1'b1, 12'hFF3, 2'd0, 1'b0, 0, 1'b1, 32'h0000_0011, 2, 0);

    // R3 type-1 layout
    access("R3 idx set", 1'b0, 12'h000, 2'd2, 1'b1, 32'h0001_2345, 1'b0, 0, 1, 0);
    push_req("R3 type1 half write", 32'h0001_2346, 4'hC, 32'hBEEF_0000, 1'b1, 32'h0);
    access("R3 type1 half write", 1'b1, 12'h006, 2'd1, 1'b1, 32'h0000_BEEF, 1'b0, 0, 2, 0);

    // R4 type-0 layout: device 11 function 3, then device 20 function 7
    access("R4 idx set a", 1'b0, 12'h000, 2'd2, 1'b1, 32'h0000_0B14, 1'b0, 0, 1, 0);
    push_req("R4 type0 dev11", 32'h0000_5B15, 4'h6, 32'h0, 1'b0, 32'hA1B2_C3D4);
    access("R7 type0 half read", 1'b1, 12'h005, 2'd1, 1'b0, 0, 1'b1, 32'h0000_B2C3, 2, 0);
    access("R4 idx set b", 1'b0, 12'h000, 2'd2, 1'b1, 32'h4010_07F8, 1'b0, 0, 1, 0);
    push_req("R4 type0 dev20", 32'h0000_A7F8, 4'hF, 32'h0102_0304, 1'b1, 32'h0);
    access("R4 type0 write", 1'b1, 12'h000, 2'd2, 1'b1, 32'h0102_0304, 1'b0, 0, 2, 0);

    // R5 empty device select
    access("R5 idx set", 1'b0, 12'h000, 2'd2, 1'b1, 32'h0000_07F8, 1'b0, 0, 1, 0);
    access("R5 invalid read", 1'b1, 12'h000, 2'd2, 1'b0, 0, 1'b1, 32'hFFFF_FFFF, 1, 0);
    access("R5 invalid write", 1'b1, 12'h004, 2'd2, 1'b1, 32'h1234_5678, 1'b0, 0, 1, 0);

    // R6 word access at lane 2 truncates enables; slower responder
    resp_delay = 3;
    access("R6 idx set", 1'b0, 12'h000, 2'd2, 1'b1, 32'h8000_0000, 1'b0, 0, 1, 0);
    push_req("R6 truncated word", 32'h8000_0002, 4'hC, 32'h7788_0000, 1'b1, 32'h0);
    access("R6 truncated word", 1'b1, 12'h002, 2'd2, 1'b1, 32'h5566_7788, 1'b0, 0, 4, 0);

    // R8 access arriving while busy is ignored
    resp_delay = 6;
    access("R8 idx set", 1'b0, 12'h000, 2'd2, 1'b1, 32'h8000_0100, 1'b0, 0, 1, 0);
    push_req("R8 busy read", 32'h8000_0100, 4'hF, 32'h0, 1'b0, 32'hCAFE_F00D);
    access("R8 busy read", 1'b1, 12'h000, 2'd2, 1'b0, 0, 1'b1, 32'hCAFE_F00D, 7, 1);
    access("R8 idx kept", 1'b0, 12'h000, 2'd2, 1'b0, 0, 1'b1, 32'h8000_0100, 1, 0);

    repeat (4) @(negedge clk);
    check("R8 requests consumed", 32'(rq_addr.size()), 32'h0);
    check("R8 completions consumed", 32'(dn_tag.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule